// File: doc/BRIEF.md
# Multiplexed Neural ADC Acquisition Sequencer

The block runs several recording headstages side by side. Each headstage carries a 32-input multiplexed amplifier that feeds a 16-bit serial ADC. For each headstage the block generates the control strobes: multiplexer step, multiplexer return-to-zero, front-end settle, convert start and serial clock. It shifts the ADC result in MSB-first, timed by the clock that the headstage sends back rather than the locally generated one. Every finished sample is tagged with its amplifier input index, a saturation flag and the headstage index.

Each sample cycle has the same shape. A one-cycle convert pulse is followed by a fixed conversion wait of `CONV_CYC` system clocks. Then come sixteen serial clock periods of `2*HALF_CYC` clocks each. The sample is captured and the multiplexer is stepped. The samples of all headstages merge into one small FIFO, which a host-side consumer drains over a valid/ready stream. With the defaults at 125 MHz, a cycle is about 900 ns of conversion plus 16 bit periods of 48 ns.

Top module: `acq_top`

## Requirements
- R1: While reset is held and right after it, all strobes and serial clocks are low, `m_valid` is 0 and `ovf` is 0.
- R2: Each sample cycle begins with a one-cycle convert pulse. The multiplexer-reset strobe is asserted in the same cycle as the convert pulse of every sample tagged channel 0, and at no other time.
- R3: The serial clock stays low during conversion. Its first rising edge comes exactly `CONV_CYC` clocks after the convert pulse. It then gives exactly 16 periods per sample, each high for `HALF_CYC` clocks and then low for `HALF_CYC` clocks.
- R4: The 16 data bits are sampled on rising edges of the returned serial clock, first bit as the MSB. The captured word is reported in `m_data[15:0]`.
- R5: The channel tag `m_chan` counts 0,1,…,31 per headstage and wraps from 31 to 0. The step strobe pulses for one cycle after each readout, in the cycle before the next convert pulse.
- R6: A sample equal to 0x0000 or 0xFFFF has `m_sat`=1, and all other samples have 0. After a saturated sample the settle line of that headstage is high until the next sample of that headstage completes. A non-saturated sample drives it low.
- R7: While `m_valid`=1 and `m_ready`=0, the payload holds steady. `m_hs` gives the headstage index (0..N_HS-1), and each headstage's samples come out in capture order.
- R8: When the FIFO is full, samples that arrive are discarded and `ovf` goes to 1. It stays at 1 until reset.
- R9: Samples that complete on several headstages in the same cycle are all delivered as long as the FIFO has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_step | output | N_HS | Multiplexer step pulse per headstage |
| hs_home | output | N_HS | Multiplexer return-to-input-0 pulse |
| hs_settle | output | N_HS | Front-end settle level |
| hs_conv | output | N_HS | ADC convert-start pulse |
| hs_sclk | output | N_HS | Serial clock to ADC |
| hs_sdata | input | N_HS | Serial data from ADC |
| hs_rclk | input | N_HS | Serial clock returned from headstage |
| m_valid | output | 1 | Stream item available |
| m_ready | input | 1 | Consumer accepts item |
| m_data | output | 16 | Captured sample |
| m_chan | output | 5 | Amplifier input index |
| m_hs | output | HS_W | Headstage index |
| m_sat | output | 1 | Sample at a rail code |
| ovf | output | 1 | Sticky FIFO overflow |

## Verification
A wrong channel counter shows up on the first stream item after the fault as a wrong `m_chan`. It also shows up as a multiplexer-reset pulse that lands away from the convert of a channel-0 sample, and for a stuck counter this is visible within 32 sample cycles. A shift or bit-count fault corrupts `m_data` on the next word, about one sample period (roughly 216 clocks) later. A sequencer fault shows within one cycle as a wrong conversion gap or a wrong serial-clock period count. A merge fault appears as a missing or reordered item for one headstage in the per-headstage scoreboard. A lost overflow latch shows as soon as the FIFO is filled.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int DATA_W = 16;
  localparam int CH_NUM = 32;
  localparam int CH_W   = $clog2(CH_NUM);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CH_W-1:0]   ch;
    logic              sat;
  } smp_t;

  typedef enum logic [2:0] {
    ST_START, ST_CONV, ST_CLK, ST_WAIT, ST_DONE
  } seq_st_t;
endpackage

// File: rtl/acq_lane.sv
module acq_lane
  import acq_pkg::*;
#(
  parameter int CONV_CYC = 113,
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sdata_i,
  input  logic rclk_i,
  output logic step_o,
  output logic home_o,
  output logic settle_o,
  output logic conv_o,
  output logic sclk_o,
  output logic pend_o,
  output smp_t smp_o,
  input  logic take_i
);
  localparam int CNT_MAX = (CONV_CYC > HALF_CYC) ? CONV_CYC : HALF_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(DATA_W + 1);

  seq_st_t             st;
  logic [CNT_W-1:0]    cnt;
  logic [BIT_W-1:0]    per, bits;
  logic [CH_W-1:0]     ch;
  logic [DATA_W-1:0]   sh;
  logic [2:0]          rc_s;
  logic [1:0]          sd_s;
  logic                rc_rise, word_sat;

  assign rc_rise  = rc_s[1] & ~rc_s[2];
  assign word_sat = (sh == '0) || (sh == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_s <= '0;
      sd_s <= '0;
    end else begin
      rc_s <= {rc_s[1:0], rclk_i};
      sd_s <= {sd_s[0], sdata_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_START;
      cnt      <= '0;
      per      <= '0;
      bits     <= '0;
      ch       <= '0;
      sh       <= '0;
      step_o   <= 1'b0;
      home_o   <= 1'b0;
      settle_o <= 1'b0;
      conv_o   <= 1'b0;
      sclk_o   <= 1'b0;
      pend_o   <= 1'b0;
      smp_o    <= '0;
    end else begin
      conv_o <= 1'b0;
      home_o <= 1'b0;
      step_o <= 1'b0;
      if (take_i) pend_o <= 1'b0;
      if ((st == ST_CLK || st == ST_WAIT) && rc_rise && bits != BIT_W'(DATA_W)) begin
        sh   <= {sh[DATA_W-2:0], sd_s[1]};
        bits <= bits + 1'b1;
      end
      case (st)
        ST_START: begin
          conv_o <= 1'b1;
          home_o <= (ch == '0);
          cnt    <= CNT_W'(CONV_CYC - 1);
          bits   <= '0;
          st     <= ST_CONV;
        end
        ST_CONV: begin
          if (cnt == '0) begin
            sclk_o <= 1'b1;
            cnt    <= CNT_W'(HALF_CYC - 1);
            per    <= '0;
            st     <= ST_CLK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CLK: begin
          if (cnt == '0) begin
            cnt <= CNT_W'(HALF_CYC - 1);
            if (sclk_o) begin
              sclk_o <= 1'b0;
            end else if (per == BIT_W'(DATA_W - 1)) begin
              st <= ST_WAIT;
            end else begin
              sclk_o <= 1'b1;
              per    <= per + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (bits == BIT_W'(DATA_W)) st <= ST_DONE;
        end
        default: begin
          smp_o    <= '{data: sh, ch: ch, sat: word_sat};
          pend_o   <= 1'b1;
          step_o   <= 1'b1;
          settle_o <= word_sat;
          ch       <= (ch == CH_W'(CH_NUM - 1)) ? '0 : ch + 1'b1;
          st       <= ST_START;
        end
      endcase
    end
  end
endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             do_wr, do_rd;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end
endmodule

// File: rtl/acq_top.sv
module acq_top
  import acq_pkg::*;
#(
  parameter int N_HS     = 3,
  parameter int CONV_CYC = 113,
  parameter int HALF_CYC = 3,
  parameter int FIFO_D   = 8,
  localparam int HS_W    = (N_HS > 1) ? $clog2(N_HS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  output logic [N_HS-1:0]     hs_step,
  output logic [N_HS-1:0]     hs_home,
  output logic [N_HS-1:0]     hs_settle,
  output logic [N_HS-1:0]     hs_conv,
  output logic [N_HS-1:0]     hs_sclk,
  input  logic [N_HS-1:0]     hs_sdata,
  input  logic [N_HS-1:0]     hs_rclk,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [DATA_W-1:0]   m_data,
  output logic [CH_W-1:0]     m_chan,
  output logic [HS_W-1:0]     m_hs,
  output logic                m_sat,
  output logic                ovf
);
  localparam int ITEM_W = HS_W + $bits(smp_t);

  logic [N_HS-1:0] pend, grant;
  smp_t            smp [N_HS];
  logic [ITEM_W-1:0] wr_item, rd_item;
  logic            any_pend, full, empty;

  for (genvar g = 0; g < N_HS; g++) begin : g_lane
    acq_lane #(.CONV_CYC(CONV_CYC), .HALF_CYC(HALF_CYC)) u_lane (
      .clk(clk), .rst(rst),
      .sdata_i(hs_sdata[g]), .rclk_i(hs_rclk[g]),
      .step_o(hs_step[g]), .home_o(hs_home[g]), .settle_o(hs_settle[g]),
      .conv_o(hs_conv[g]), .sclk_o(hs_sclk[g]),
      .pend_o(pend[g]), .smp_o(smp[g]), .take_i(grant[g])
    );
  end

  always_comb begin
    grant    = '0;
    any_pend = 1'b0;
    wr_item  = '0;
    for (int g = 0; g < N_HS; g++) begin
      if (pend[g] && !any_pend) begin
        grant[g] = 1'b1;
        any_pend = 1'b1;
        wr_item  = {HS_W'(g), smp[g]};
      end
    end
  end

  acq_fifo #(.W(ITEM_W), .DEPTH(FIFO_D)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(any_pend), .wr_data(wr_item), .full(full),
    .rd_en(m_ready), .rd_data(rd_item), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (any_pend && full) ovf <= 1'b1;
  end

  assign m_valid = !empty;
  assign {m_hs, m_data, m_chan, m_sat} = rd_item;
endmodule

// File: rtl/acq_chk.sv
module acq_chk #(
  parameter int N_HS = 3,
  parameter int HS_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [N_HS-1:0] hs_step,
  input logic [N_HS-1:0] hs_home,
  input logic [N_HS-1:0] hs_conv,
  input logic [N_HS-1:0] hs_sclk,
  input logic            m_valid,
  input logic            m_ready,
  input logic [15:0]     m_data,
  input logic [4:0]      m_chan,
  input logic [HS_W-1:0] m_hs,
  input logic            m_sat,
  input logic            ovf
);
  for (genvar g = 0; g < N_HS; g++) begin : g_chk
    // R2
    home_with_conv_chk: assert property (@(posedge clk) disable iff (rst)
      hs_home[g] |-> hs_conv[g]);
    // R2
    conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      hs_conv[g] |=> !hs_conv[g]);
    // R3
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      hs_conv[g] |-> !hs_sclk[g]);
    // R5
    step_then_conv_chk: assert property (@(posedge clk) disable iff (rst)
      hs_step[g] |=> (hs_conv[g] && !hs_step[g]));
  end

  // R7
  hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable({m_data, m_chan, m_hs, m_sat})));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind acq_top acq_chk #(.N_HS(N_HS), .HS_W(HS_W)) u_chk (
  .clk(clk), .rst(rst), .hs_step(hs_step), .hs_home(hs_home),
  .hs_conv(hs_conv), .hs_sclk(hs_sclk), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_chan(m_chan), .m_hs(m_hs), .m_sat(m_sat), .ovf(ovf)
);

// File: tb/tb_acq_top.sv
module tb_acq_top;
  localparam int NH = 3, CONV = 113, HALF = 3, HW = 2;

  logic clk = 1'b0, rst = 1'b1, m_ready = 1'b0;
  logic [NH-1:0] hs_step, hs_home, hs_settle, hs_conv, hs_sclk;
  logic [NH-1:0] hs_sdata = '0, hs_rclk = '0;
  logic m_valid, m_sat, ovf;
  logic [15:0] m_data;
  logic [4:0]  m_chan;
  logic [HW-1:0] m_hs;

  int n_chk = 0, n_bad = 0;
  bit ovf_phase = 0, done = 0;

  always #4 clk = ~clk;
  always @(hs_sclk) hs_rclk <= #3 hs_sclk;

  acq_top #(.N_HS(NH), .CONV_CYC(CONV), .HALF_CYC(HALF), .FIFO_D(8)) dut (
    .clk(clk), .rst(rst), .hs_step(hs_step), .hs_home(hs_home),
    .hs_settle(hs_settle), .hs_conv(hs_conv), .hs_sclk(hs_sclk),
    .hs_sdata(hs_sdata), .hs_rclk(hs_rclk), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan), .m_hs(m_hs),
    .m_sat(m_sat), .ovf(ovf));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] gen(int h, int n);
    logic [15:0] v;
    if (n % 11 == 4) return 16'h0000;
    if (n % 13 == 7) return 16'hFFFF;
    v = 16'(n * 40503 + h * 12345 + 771);
    if (v == 16'h0000 || v == 16'hFFFF) v ^= 16'h00F0;
    return v;
  endfunction

  logic [21:0] q0[$], q1[$], q2[$];
  logic [15:0] word [NH];
  int idx [NH];
  int nsmp [NH];
  logic [NH-1:0] rc_prev = '0;

  int nconv0 = 0, nstep0 = 0, srise = 0, gap = 0, hi_len = 0;
  logic sclk_prev = 1'b0, in_gap = 1'b0;
  logic hold_prev = 1'b0;
  logic [23:0] hold_val = '0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      // ADC model and scoreboard driver
      for (int h = 0; h < NH; h++) begin
        if (hs_conv[h]) begin
          logic [15:0] w;
          logic [21:0] e;
          w = gen(h, nsmp[h]);
          word[h] = w;
          idx[h] = 0;
          hs_sdata[h] = w[15];
          e = {(w == 16'h0000 || w == 16'hFFFF), 5'(nsmp[h] % 32), w};
          if (!ovf_phase) begin
            case (h)
              0: q0.push_back(e);
              1: q1.push_back(e);
              default: q2.push_back(e);
            endcase
          end
          nsmp[h]++;
        end else if (rc_prev[h] && !hs_rclk[h]) begin
          idx[h]++;
          if (idx[h] < 16) hs_sdata[h] = word[h][15 - idx[h]];
        end
      end
      rc_prev = hs_rclk;

      // strobe timing on headstage 0
      if (hs_conv[0]) begin
        chk(hs_home[0] == (nconv0 % 32 == 0), "R2", "home with conv", hs_home[0], (nconv0 % 32 == 0));
        if (nconv0 > 0) chk(srise == 16, "R3", "sclk periods", srise, 16);
        nconv0++;
        srise = 0;
        gap = 0;
        in_gap = 1;
      end else if (hs_home[0]) begin
        chk(0, "R2", "home without conv", 1, 0);
      end
      if (hs_step[0]) nstep0++;
      if (in_gap) gap++;
      if (hs_sclk[0] && !sclk_prev) begin
        if (srise == 0) begin
          chk(gap - 1 == CONV, "R3", "conv-to-sclk gap", gap - 1, CONV);
          in_gap = 0;
        end
        srise++;
        hi_len = 0;
      end
      if (hs_sclk[0]) hi_len++;
      if (!hs_sclk[0] && sclk_prev && nconv0 < 3)
        chk(hi_len == HALF, "R3", "sclk high length", hi_len, HALF);
      sclk_prev = hs_sclk[0];

      // stream monitor
      if (hold_prev)
        chk(m_valid && {m_hs, m_data, m_chan, m_sat} == hold_val, "R7", "held payload",
            int'({m_hs, m_data, m_chan, m_sat}), int'(hold_val));
      hold_prev = m_valid && !m_ready;
      hold_val = {m_hs, m_data, m_chan, m_sat};
      if (m_valid && m_ready && !ovf_phase) begin
        logic [21:0] e;
        logic ok;
        ok = 1;
        case (m_hs)
          2'd0: if (q0.size() > 0) e = q0.pop_front(); else ok = 0;
          2'd1: if (q1.size() > 0) e = q1.pop_front(); else ok = 0;
          2'd2: if (q2.size() > 0) e = q2.pop_front(); else ok = 0;
          default: ok = 0;
        endcase
        chk(ok, "R7", "headstage tag / unexpected item", m_hs, 0);
        if (ok) begin
          chk(m_data == e[15:0], "R4", "sample word", m_data, e[15:0]);
          chk(m_chan == e[20:16], "R5", "channel tag", m_chan, e[20:16]);
          chk(m_sat == e[21], "R6", "saturation flag", m_sat, e[21]);
          chk(hs_settle[m_hs] == e[21], "R6", "settle level", hs_settle[m_hs], e[21]);
        end
      end
    end
  end

  initial begin
    for (int h = 0; h < NH; h++) begin nsmp[h] = 0; idx[h] = 0; word[h] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({hs_step, hs_home, hs_settle, hs_conv, hs_sclk} == '0, "R1", "strobes in reset", 0, 0);
    chk(!m_valid && !ovf, "R1", "stream/ovf in reset", {m_valid, ovf}, 0);
    @(posedge clk);
    rst <= 1'b0;
    m_ready <= 1'b1;
    @(negedge clk);
    chk({hs_step, hs_home, hs_settle, hs_sclk} == '0 && !m_valid, "R1", "after reset", 0, 0);
    // stall a while to exercise holding under backpressure
    repeat (400) @(posedge clk);
    m_ready <= 1'b0;
    repeat (300) @(posedge clk);
    m_ready <= 1'b1;
    // normal run across a channel wrap
    repeat (9000) @(posedge clk);
    @(negedge clk);
    chk(nstep0 >= nconv0 - 1 && nstep0 <= nconv0, "R5", "step count", nstep0, nconv0);
    chk(nsmp[0] > 34, "R5", "wrap reached", nsmp[0], 35);
    chk(q0.size() + q1.size() + q2.size() <= 3, "R9", "undelivered items",
        q0.size() + q1.size() + q2.size(), 0);
    chk(!ovf, "R8", "no overflow while draining", ovf, 0);
    // overflow phase
    ovf_phase = 1;
    @(posedge clk);
    m_ready <= 1'b0;
    repeat (1500) @(posedge clk);
    @(negedge clk);
    chk(ovf, "R8", "overflow set", ovf, 1);
    chk(m_valid, "R8", "fifo holding data", m_valid, 1);
    @(posedge clk);
    m_ready <= 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(ovf, "R8", "overflow sticky", ovf, 1);
    done = 1;
    @(posedge clk);
    rst <= 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!ovf && !m_valid, "R8", "overflow cleared by reset", ovf, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule